// File: doc/BRIEF.md
# Cascaded FIFO with Token-Passing Depth Expansion

This block builds one deep first-in/first-out queue out of several identical small FIFO slices. Two tokens travel around the slices, one for writing and one for reading. The slices are joined in a ring by expansion signals. Every slice sees the shared write enable, read enable and write data. Only the slice that holds the write token stores a word. Only the slice that holds the read token pops a word and drives the shared read bus. Each slice fills its own storage from location 0 up to its last physical location. When it writes that last location, it pulses its write-expansion output, and the write token moves to the next slice in the ring. The read token moves in the same way when a slice reads its last location. The order of words across the whole cascade is therefore the order in which they were written.

After reset, one slice holds both tokens. That slice is the one whose first-load strap is low, which is slice 0. All other slices start without tokens. The top level combines the flags of the individual slices into one set of cascade status flags. When the top is built with a single slice, its expansion inputs are tied low, it never gives up its tokens, and it provides a half-full flag. The read port shows the head word ahead of the pop: while `empty` is low, `rd_data` already holds the oldest word, and a cycle with `rd_en` high removes that word.

Top module: `cascade_fifo`

## Requirements
- R1: During and right after reset, slice 0 holds both tokens and the cascade is empty: `empty`=1, `almost_empty`=1, `full`=0, `almost_full`=0, `half_full`=0.
- R2: A write with `wr_en`=1 is stored only by the slice that holds the write token, at its next location in order 0..SLICE_DEPTH-1. Writing the last location passes the write token to slice (index+1) mod NUM_SLICES, which takes the next write.
- R3: A read with `rd_en`=1 pops only from the slice that holds the read token, in location order. Reading the last location passes the read token to slice (index+1) mod NUM_SLICES.
- R4: At every cycle after reset, exactly one slice holds the write token and exactly one slice holds the read token.
- R5: While `empty`=0, `rd_data` shows the oldest unread word. Over any mix of reads and writes, words come out in the order they were written, including across every token handoff. Slices without the read token drive zeros onto the shared read bus.
- R6: `full` is 1 exactly when the write-token slice holds SLICE_DEPTH words. A write while `full`=1 is dropped.
- R7: `empty` is 1 exactly when the read-token slice holds no words. A read while `empty`=1 has no effect.
- R8: `almost_full` is 1 when the write-token slice holds at least SLICE_DEPTH-AF_GAP words.
- R9: `almost_empty` is 1 when the read-token slice holds at most AE_GAP words.
- R10: With NUM_SLICES=1, the slice keeps both tokens forever and works as a plain FIFO of SLICE_DEPTH words. `half_full` is 1 when it holds more than SLICE_DEPTH/2 words.
- R11: With NUM_SLICES>1, `half_full` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all slices |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write request, sent to every slice |
| wr_data | input | DATA_W | Word to be written |
| rd_en | input | 1 | Read request (pops the head word) |
| rd_data | output | DATA_W | Head word of the cascade, valid while empty is 0 |
| full | output | 1 | Write-token slice is full |
| empty | output | 1 | Read-token slice is empty |
| almost_full | output | 1 | Write-token slice is near its capacity |
| almost_empty | output | 1 | Read-token slice is near empty |
| half_full | output | 1 | Single-slice mode only: more than half full |

## Verification
The bench fills the cascade until the write token has gone all the way round the ring and comes back to a slice that is still full. It then drains the cascade until the read token finds an empty slice. At both ends it makes extra requests that must be dropped. A handoff that comes one cycle late, or that goes to the wrong slice, would shift or repeat words, and the scoreboard compares every head word, so it would catch this. Long runs of simultaneous reads and writes, with the two tokens in different slices, show that the flags follow the owning slice and not any other one. A separate single-slice instance shows that the token never leaves the slice and that the half-full threshold is exact.

// File: rtl/cascade_pkg.sv
package cascade_pkg;
    // Per-slice status after gating by token ownership
    typedef struct packed {
        logic full;
        logic empty;
        logic afull;
        logic aempty;
        logic half;
    } slice_flags_t;
endpackage

// File: rtl/token_keeper.sv
module token_keeper (
    input  logic clk,
    input  logic rst_n,
    input  logic first_n,
    input  logic pass_in,
    input  logic send,
    input  logic keep,
    output logic own
);
    typedef struct packed {
        logic own;
    } tok_state_t;

    tok_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.own) begin
            if (send && !keep) st_d.own = 1'b0;
        end else if (pass_in) begin
            st_d.own = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.own <= !first_n;
        else        st_q <= st_d;
    end

    assign own = st_q.own;

    // R4: a pulse never reaches a slice that already holds this token
    assert_no_double_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pass_in |-> !st_q.own);
    // R2: only the holder may send the token onward
    assert_send_by_owner_R2: assert property (@(posedge clk) disable iff (!rst_n)
        send |-> st_q.own);
endmodule

// File: rtl/slice_store.sv
module slice_store #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              do_wr,
    input  logic              do_rd,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic              wr_last,
    output logic              rd_last
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH-1);

    typedef struct packed {
        logic [PW-1:0] wptr;
        logic [PW-1:0] rptr;
        logic [CW-1:0] cnt;
    } store_state_t;

    store_state_t st_d, st_q;
    logic [DATA_W-1:0] mem [DEPTH];

    always_comb begin
        st_d = st_q;
        if (do_wr) st_d.wptr = (st_q.wptr == LAST) ? '0 : st_q.wptr + PW'(1);
        if (do_rd) st_d.rptr = (st_q.rptr == LAST) ? '0 : st_q.rptr + PW'(1);
        case ({do_wr, do_rd})
            2'b10:   st_d.cnt = st_q.cnt + CW'(1);
            2'b01:   st_d.cnt = st_q.cnt - CW'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_wr) mem[st_q.wptr] <= wdata;
    end

    assign rdata   = mem[st_q.rptr];
    assign count   = st_q.cnt;
    assign wr_last = (st_q.wptr == LAST);
    assign rd_last = (st_q.rptr == LAST);

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH));
    assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        do_rd |-> (st_q.cnt != '0));
endmodule

// File: rtl/fifo_slice.sv
module fifo_slice
    import cascade_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8,
    parameter int AF_GAP = 2,
    parameter int AE_GAP = 2,
    parameter bit SINGLE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              first_n,
    input  logic              wx_in,
    input  logic              rx_in,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic              wx_out,
    output logic              rx_out,
    output logic [DATA_W-1:0] rdata,
    output slice_flags_t      flags,
    output logic              wtok,
    output logic              rtok
);
    localparam int CW = $clog2(DEPTH+1);

    logic [CW-1:0]     count;
    logic              wr_last, rd_last, do_wr, do_rd;
    logic [DATA_W-1:0] store_rdata;

    assign do_wr  = wr_en && wtok && (count != CW'(DEPTH));
    assign do_rd  = rd_en && rtok && (count != '0);
    assign wx_out = do_wr && wr_last;
    assign rx_out = do_rd && rd_last;

    token_keeper u_wtok (
        .clk(clk), .rst_n(rst_n), .first_n(first_n), .pass_in(wx_in),
        .send(wx_out), .keep(SINGLE), .own(wtok)
    );

    token_keeper u_rtok (
        .clk(clk), .rst_n(rst_n), .first_n(first_n), .pass_in(rx_in),
        .send(rx_out), .keep(SINGLE), .own(rtok)
    );

    slice_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .do_wr(do_wr), .do_rd(do_rd),
        .wdata(wdata), .rdata(store_rdata), .count(count),
        .wr_last(wr_last), .rd_last(rd_last)
    );

    assign rdata = rtok ? store_rdata : '0;

    always_comb begin
        flags.full   = wtok && (count == CW'(DEPTH));
        flags.afull  = wtok && (count >= CW'(DEPTH - AF_GAP));
        flags.empty  = rtok && (count == '0);
        flags.aempty = rtok && (count <= CW'(AE_GAP));
        flags.half   = (count > CW'(DEPTH / 2));
    end

    // R2 / R3: a handoff pulse in a ring releases the token at that edge
    assert_wr_handoff_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!SINGLE && wx_out) |=> !wtok);
    assert_rd_handoff_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!SINGLE && rx_out) |=> !rtok);
    assert_single_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !SINGLE || (wtok && rtok));
endmodule

// File: rtl/cascade_fifo.sv
module cascade_fifo
    import cascade_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int SLICE_DEPTH = 8,
    parameter int NUM_SLICES  = 4,
    parameter int AF_GAP      = 2,
    parameter int AE_GAP      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              full,
    output logic              empty,
    output logic              almost_full,
    output logic              almost_empty,
    output logic              half_full
);
    localparam bit SOLO = (NUM_SLICES == 1);

    logic [NUM_SLICES-1:0] wx_o, rx_o, wx_i, rx_i, wtok, rtok;
    logic [DATA_W-1:0]     sl_rdata [NUM_SLICES];
    slice_flags_t          sl_flags [NUM_SLICES];
    logic                  any_half;

    for (genvar i = 0; i < NUM_SLICES; i++) begin : g_slice
        if (SOLO) begin : g_solo
            assign wx_i[i] = 1'b0;
            assign rx_i[i] = 1'b0;
        end else begin : g_ring
            assign wx_i[i] = wx_o[(i + NUM_SLICES - 1) % NUM_SLICES];
            assign rx_i[i] = rx_o[(i + NUM_SLICES - 1) % NUM_SLICES];
        end

        fifo_slice #(
            .DATA_W(DATA_W), .DEPTH(SLICE_DEPTH),
            .AF_GAP(AF_GAP), .AE_GAP(AE_GAP), .SINGLE(SOLO)
        ) u_slice (
            .clk(clk), .rst_n(rst_n), .first_n(i != 0),
            .wx_in(wx_i[i]), .rx_in(rx_i[i]),
            .wr_en(wr_en), .rd_en(rd_en), .wdata(wr_data),
            .wx_out(wx_o[i]), .rx_out(rx_o[i]),
            .rdata(sl_rdata[i]), .flags(sl_flags[i]),
            .wtok(wtok[i]), .rtok(rtok[i])
        );
    end

    always_comb begin
        rd_data      = '0;
        full         = 1'b0;
        empty        = 1'b0;
        almost_full  = 1'b0;
        almost_empty = 1'b0;
        any_half     = 1'b0;
        for (int i = 0; i < NUM_SLICES; i++) begin
            rd_data      = rd_data | sl_rdata[i];
            full         = full | sl_flags[i].full;
            empty        = empty | sl_flags[i].empty;
            almost_full  = almost_full | sl_flags[i].afull;
            almost_empty = almost_empty | sl_flags[i].aempty;
            any_half     = any_half | sl_flags[i].half;
        end
        half_full = SOLO ? any_half : 1'b0;
    end

    assert_one_wtoken_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(wtok));
    assert_one_rtoken_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(rtok));
    // R5: at most one slice drives the shared read bus
    assert_one_driver_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rtok));
endmodule

// File: tb/cascade_fifo_test.sv
`timescale 1ns/1ps
module cascade_fifo_test;
    localparam int DW = 16;
    localparam int D  = 8;
    localparam int N  = 4;
    localparam int AF = 2;
    localparam int AE = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          wr_en = 0, rd_en = 0;
    logic [DW-1:0] wr_data = '0, rd_data;
    logic          full, empty, almost_full, almost_empty, half_full;

    cascade_fifo #(.DATA_W(DW), .SLICE_DEPTH(D), .NUM_SLICES(N),
                   .AF_GAP(AF), .AE_GAP(AE)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .full(full), .empty(empty),
        .almost_full(almost_full), .almost_empty(almost_empty),
        .half_full(half_full)
    );

    logic          s_wr = 0, s_rd = 0;
    logic [DW-1:0] s_wd = '0, s_rdata;
    logic          s_full, s_empty, s_af, s_ae, s_half;

    cascade_fifo #(.DATA_W(DW), .SLICE_DEPTH(D), .NUM_SLICES(1),
                   .AF_GAP(AF), .AE_GAP(AE)) uut1 (
        .clk(clk), .rst_n(rst_n), .wr_en(s_wr), .wr_data(s_wd),
        .rd_en(s_rd), .rd_data(s_rdata), .full(s_full), .empty(s_empty),
        .almost_full(s_af), .almost_empty(s_ae), .half_full(s_half)
    );

    int checks = 0, failures = 0;
    logic [DW-1:0] sb[$];
    logic [DW-1:0] ssb[$];
    int cnt[N], wp[N], rp[N];
    int wt = 0, rt = 0, scnt = 0;
    logic [DW-1:0] next_word = 16'hA000;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Monitor: compares outputs with the model, pops the scoreboard on reads
    task automatic monitor(input bit r, output bit rd_ok, output bit wr_ok);
        bit e_full, e_empty;
        e_full  = (cnt[wt] == D);
        e_empty = (cnt[rt] == 0);
        chk(full == e_full, "R6 full", full, e_full);
        chk(empty == e_empty, "R7 empty", empty, e_empty);
        chk(almost_full == (cnt[wt] >= D - AF), "R8 almost_full", almost_full, cnt[wt] >= D - AF);
        chk(almost_empty == (cnt[rt] <= AE), "R9 almost_empty", almost_empty, cnt[rt] <= AE);
        chk(half_full == 1'b0, "R11 half_full", half_full, 0);
        // R5 with R2/R3 handoffs; R4: a duplicate token holder would break order
        if (!e_empty && sb.size() > 0)
            chk(rd_data == sb[0], "R5 head word", rd_data, sb[0]);
        rd_ok = r && !e_empty;
        wr_ok = !e_full;
        if (rd_ok) begin
            void'(sb.pop_front());
            cnt[rt]--;
            if (rp[rt] == D - 1) begin rp[rt] = 0; rt = (rt + 1) % N; end
            else rp[rt]++;
        end
    endtask

    // Driver: applies one cycle of stimulus and pushes accepted writes
    task automatic drive(input bit w, input bit r);
        bit rd_ok, wr_ok;
        @(negedge clk);
        monitor(r, rd_ok, wr_ok);
        wr_en = w; rd_en = r; wr_data = next_word;
        if (w && wr_ok) begin
            sb.push_back(next_word);
            cnt[wt]++;
            if (wp[wt] == D - 1) begin wp[wt] = 0; wt = (wt + 1) % N; end
            else wp[wt]++;
        end
        if (w) next_word++;
    endtask

    task automatic sdrive(input bit w, input bit r);
        bit ok_r, ok_w;
        @(negedge clk);
        chk(s_full == (scnt == D), "R10 single full", s_full, scnt == D);
        chk(s_empty == (scnt == 0), "R10 single empty", s_empty, scnt == 0);
        chk(s_half == (scnt > D / 2), "R10 half_full", s_half, scnt > D / 2);
        if (scnt > 0) chk(s_rdata == ssb[0], "R10 single order", s_rdata, ssb[0]);
        ok_r = r && scnt > 0;
        ok_w = w && scnt < D;
        s_wr = w; s_rd = r; s_wd = next_word;
        if (ok_r) begin void'(ssb.pop_front()); scnt--; end
        if (ok_w) begin ssb.push_back(next_word); scnt++; end
        if (w) next_word++;
    endtask

    initial begin
        #(5.0 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        foreach (cnt[i]) begin cnt[i] = 0; wp[i] = 0; rp[i] = 0; end
        repeat (3) @(negedge clk);
        // R1: state held under reset
        chk(empty == 1 && almost_empty == 1, "R1 reset empty flags", {empty, almost_empty}, 2'b11);
        chk(full == 0 && almost_full == 0 && half_full == 0, "R1 reset full flags",
            {full, almost_full, half_full}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(empty == 1 && full == 0, "R1 after reset", {empty, full}, 2'b10);

        for (int k = 0; k < 5; k++) drive(1, 0);
        for (int k = 0; k < 7; k++) drive(0, 1);     // last two hit empty (R7)
        for (int k = 0; k < 36; k++) drive(1, 0);    // wraps ring, hits full (R6)
        for (int k = 0; k < 36; k++) drive(0, 1);    // drains across handoffs (R3)
        for (int k = 0; k < 300; k++) drive(k % 3 != 0, k % 5 < 3);
        for (int k = 0; k < 600; k++) drive($urandom_range(0, 3) != 0, $urandom_range(0, 2) != 0);
        for (int k = 0; k < 40; k++) drive(0, 1);
        for (int k = 0; k < 200; k++) drive($urandom_range(0, 1) == 1, $urandom_range(0, 3) == 0);
        for (int k = 0; k < 40; k++) drive(0, 1);
        drive(0, 0);

        // R10: one slice keeps both tokens and reports half full
        for (int k = 0; k < 10; k++) sdrive(1, 0);
        for (int k = 0; k < 4; k++) sdrive(1, 1);
        for (int k = 0; k < 10; k++) sdrive(0, 1);
        sdrive(0, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule